// File: doc/BRIEF.md
# Stream Occurrence Counter

This unit reads a stream of words and, for each one, reports how many entries of a fixed table of N words equal that word. The table is a register array. It is filled from a parameter whenever reset is asserted and is never written while the unit runs. Words arrive on a valid/ready input stream. Each count leaves on a valid/ready output stream as a word of the same width.

A small automaton with three steps sequences the work.

- **Fetch:** latches the arriving word and clears both the match count and the scan index.
- **Test:** compares one table entry against the latched word and records the outcome in a one-bit flag. When the scan is over, it presents the count instead.
- **Step:** advances the index, and also advances the count when the flag is set.

The scan index has one bit more than the table address. That top bit becomes 1 exactly when all N entries have been visited. Without back-pressure, one word therefore occupies the unit for exactly 2+2N cycles.

Top module: `occurrence_counter`

## Requirements
- R1: While reset is active and in the first cycle after it, `in_ready` is 1 and `out_valid` is 0.
- R2: A word is taken on a clock edge where `in_valid` and `in_ready` are both 1. From the next cycle, `in_ready` stays 0 until that word's result has been handed over.
- R3: The delivered `out_count` equals the number of table entries i (0 ≤ i < N) whose value equals the accepted word. This is 0 when nothing matches and N when every entry matches.
- R4: `out_valid` first reads 1 exactly 2N clock edges after the accepting edge. The following handshake edge completes a service time of 2+2N cycles.
- R5: While `out_valid` is 1 and `out_ready` is 0, `out_valid` stays 1, `out_count` stays unchanged and `in_ready` stays 0.
- R6: After the edge where `out_valid` and `out_ready` are both 1, `in_ready` is 1 in the next cycle.
- R7: Changes on `in_data` and `in_valid` after a word has been accepted and before its result is handed over have no effect on that result.
- R8: The table is loaded at reset from parameter `TABLE_INIT`, with entry i taken from bits [i*W +: W]. The count never exceeds N.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset; reloads the table |
| in_valid | input | 1 | Input word present |
| in_ready | output | 1 | Unit idle and able to take a word |
| in_data | input | W | Word to search for |
| out_valid | output | 1 | Count available |
| out_ready | input | 1 | Consumer takes the count |
| out_count | output | W | Number of matching table entries |

## Verification
The main instance is built with N=8 and a table holding repeated values, so counts of 0, 1, 2 and 4 all occur, both in directed runs and in random runs drawn from a pool that is biased toward table values. Back-pressure of up to three cycles and noise on the input during the scan exercise the holding and ignoring behaviour. A second instance, with N=2 and both entries equal, reaches the full count N and the shortest legal scan, where the index's top bit is set after only two steps.

// File: rtl/occurrence_counter.sv
module occurrence_counter #(
  parameter int N = 8,
  parameter int W = 32,
  parameter logic [N*W-1:0] TABLE_INIT = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_data,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_count
);

  localparam int IW = (N > 1) ? $clog2(N) : 1;

  typedef enum logic [1:0] {ST_FETCH, ST_TEST, ST_STEP} st_t;

  st_t         st;
  logic [W-1:0] b_q, c_q;
  logic [IW:0]  j_q;
  logic         z_q;
  logic [W-1:0] tbl [N];

  logic done, hit;

  assign done      = j_q[IW];
  assign hit       = (tbl[j_q[IW-1:0]] == b_q);
  assign in_ready  = (st == ST_FETCH);
  assign out_valid = (st == ST_TEST) && done;
  assign out_count = c_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st  <= ST_FETCH;
      b_q <= '0;
      c_q <= '0;
      j_q <= '0;
      z_q <= 1'b0;
      for (int i = 0; i < N; i++) tbl[i] <= TABLE_INIT[i*W +: W];
    end else begin
      case (st)
        ST_FETCH: if (in_valid) begin
          b_q <= in_data;
          c_q <= '0;
          j_q <= '0;
          st  <= ST_TEST;
        end
        ST_TEST: if (!done) begin
          z_q <= hit;
          st  <= ST_STEP;
        end else if (out_ready) begin
          st  <= ST_FETCH;
        end
        ST_STEP: begin
          j_q <= j_q + 1'b1;
          if (z_q) c_q <= c_q + 1'b1;
          st  <= ST_TEST;
        end
        default: st <= ST_FETCH;
      endcase
    end
  end

  assert_accept_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> !in_ready);

  assert_count_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_count <= W'(N)));

  assert_index_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
    j_q <= (IW+1)'(N));

  assert_step_adds_flag_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_STEP) |=> (c_q == $past(c_q) + W'($past(z_q))));

  assert_hold_on_stall_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_count) && !in_ready));

  assert_release_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready) |=> in_ready);

endmodule

// File: tb/test_occurrence_counter.sv
module test_occurrence_counter;

  localparam int N = 8;
  localparam int W = 32;
  localparam logic [N*W-1:0] TBL = {32'd5, 32'd7, 32'hFFFF_FFFF, 32'd0,
                                    32'd5, 32'd5, 32'd7, 32'd5};
  localparam logic [2*W-1:0] TBL2 = {32'd9, 32'd9};

  logic clk = 0, rst_n = 0;
  logic in_valid = 0, out_ready = 0;
  logic [W-1:0] in_data = '0;
  logic in_ready, out_valid;
  logic [W-1:0] out_count;

  logic s_in_valid = 0, s_out_ready = 0;
  logic [W-1:0] s_in_data = '0;
  logic s_in_ready, s_out_valid;
  logic [W-1:0] s_out_count;

  int n_checks = 0, n_fail = 0, cyc = 0;

  always #5 clk = ~clk;

  occurrence_counter #(.N(N), .W(W), .TABLE_INIT(TBL)) i_occurrence_counter (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .out_valid(out_valid), .out_ready(out_ready),
    .out_count(out_count));

  occurrence_counter #(.N(2), .W(W), .TABLE_INIT(TBL2)) i_occurrence_counter_n2 (
    .clk(clk), .rst_n(rst_n), .in_valid(s_in_valid), .in_ready(s_in_ready),
    .in_data(s_in_data), .out_valid(s_out_valid), .out_ready(s_out_ready),
    .out_count(s_out_count));

  function automatic logic [W-1:0] expect_count(logic [W-1:0] w);
    logic [W-1:0] n = '0;
    for (int i = 0; i < N; i++) if (TBL[i*W +: W] == w) n++;
    return n;
  endfunction

  task automatic check(bit ok, string req, logic [W-1:0] act, logic [W-1:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=<150000", cyc);
      finish_run();
    end
  end

  task automatic run_item(logic [W-1:0] w, int stall);
    int e;
    logic [W-1:0] held;
    @(negedge clk);
    check(in_ready == 1'b1, "R6 idle before item", W'(in_ready), 1);
    in_valid = 1; in_data = w;
    @(posedge clk);
    @(negedge clk);
    in_valid = ($urandom % 2) == 1;
    in_data = $urandom;
    check(in_ready == 1'b0, "R2 busy after accept", W'(in_ready), 0);
    e = 0;
    while (!out_valid && e < 1000) begin
      @(posedge clk); @(negedge clk);
      e++;
      if (!out_valid) begin in_data = $urandom; in_valid = ($urandom % 2) == 1; end
    end
    check(e == 2*N, "R4 latency", W'(e), W'(2*N));
    check(out_count == expect_count(w), "R3 R7 count", out_count, expect_count(w));
    held = out_count;
    for (int k = 0; k < stall; k++) begin
      @(posedge clk); @(negedge clk);
      check(out_valid && out_count == held && !in_ready, "R5 stall hold", out_count, held);
    end
    in_valid = 0;
    out_ready = 1;
    @(posedge clk); @(negedge clk);
    out_ready = 0;
    check(in_ready == 1'b1 && !out_valid, "R6 release", W'(in_ready), 1);
  endtask

  initial begin
    int seed;
    int e;
    logic [W-1:0] pool [5];
    seed = $urandom(32'd4711);
    pool[0] = 32'd0; pool[1] = 32'd5; pool[2] = 32'd7; pool[3] = 32'hFFFF_FFFF; pool[4] = 32'd3;

    repeat (3) @(posedge clk);
    @(negedge clk);
    check(in_ready == 1'b1 && out_valid == 1'b0, "R1 reset state", W'({in_ready, out_valid}), 2);
    rst_n = 1;
    @(negedge clk);
    check(in_ready == 1'b1 && out_valid == 1'b0, "R1 after reset", W'({in_ready, out_valid}), 2);

    run_item(32'd5, 0);
    run_item(32'd7, 2);
    run_item(32'd3, 0);
    run_item(32'hFFFF_FFFF, 3);
    run_item(32'd0, 1);
    for (int t = 0; t < 40; t++) begin
      logic [W-1:0] w;
      w = (($urandom % 4) == 0) ? $urandom : pool[$urandom % 5];
      run_item(w, $urandom % 4);
    end

    @(negedge clk);
    s_in_valid = 1; s_in_data = 32'd9;
    @(posedge clk); @(negedge clk);
    s_in_valid = 0; s_in_data = 32'd1;
    e = 0;
    while (!s_out_valid && e < 100) begin @(posedge clk); @(negedge clk); e++; end
    check(e == 4, "R4 N=2 latency", W'(e), 4);
    check(s_out_count == 32'd2, "R3 R8 full count N=2", s_out_count, 2);
    s_out_ready = 1;
    @(posedge clk); @(negedge clk);
    s_out_ready = 0;
    check(s_in_ready == 1'b1, "R6 N=2 release", W'(s_in_ready), 1);

    rst_n = 0;
    @(posedge clk); @(negedge clk);
    rst_n = 1;
    run_item(32'd5, 0);

    finish_run();
  end

endmodule